// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Fall-Through Output

This block is a synchronous FIFO. It runs on one clock and has a build-time parameter that picks one of two output styles. In standard style, a word is requested with a read enable and appears on the read data port on the next clock. In fall-through style, the oldest stored word is always shown on the read data port, and a read enable moves the queue on to the next word.

Occupancy comes from the gap between a write pointer and a read pointer. Each pointer carries one more bit than the storage address needs. The queue is empty when the two pointers are equal. It is full when their address bits match and their extra top bits differ.

The two styles treat a read on an empty queue differently. In standard style, such a read is illegal and the block ignores it. In fall-through style, if a write arrives in the same cycle, the written word goes straight to the output and nothing is stored.

Top module: `fallthru_fifo`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears both pointers. After reset `empty` is 1 and `full` is 0, and `rd_data` is all zeros in both styles.
- R2: `empty` is 1 exactly when the pointer gap is zero. After an equal number of accepted writes and accepted reads, `empty` returns to 1. `empty` and `full` are never both 1.
- R3: `full` is 1 once 2**ADDR_W words are held. A write while `full` is 1 is dropped: the stored contents and their order are unchanged.
- R4: Words leave in the order they were accepted.
- R5: In standard style (MODE = 0), the word taken by an accepted read appears on `rd_data` after the clock edge that accepts the read, and stays there until the next accepted read.
- R6: In standard style, a read while `empty` is 1 is ignored. The read pointer and `rd_data` are unchanged. A write in the same cycle is still stored, so `empty` falls after that edge.
- R7: In fall-through style (MODE = 1), while `empty` is 0, `rd_data` shows the oldest stored word with no read enable. A read enable moves `rd_data` to the next word after the clock edge.
- R8: In fall-through style, when `empty` is 1 and `wr_en` and `rd_en` are both 1, `rd_data` equals `wr_data` in that same cycle. The word is not stored, and `empty` is still 1 after the edge. While `empty` is 1 and no such bypass happens, `rd_data` is all zeros.
- R9: A read and a write accepted in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request (standard style) or advance request (fall-through style) |
| rd_data | output | DATA_W | Output word |
| empty | output | 1 | No words held |
| full | output | 1 | All 2**ADDR_W entries held |

## Verification
Both styles are instantiated side by side. They are driven with the same stimulus, which is a table of write-only, read-only, idle and combined cycles. Each style is compared with its own queue model.

Combined read and write cycles on an empty queue show the difference between the styles. In fall-through style they must bypass and leave the queue empty. In standard style they must store the word and ignore the read. The same combined cycles on a partly filled queue show that occupancy stays constant.

Filling past capacity and then draining past empty checks two things. It shows that dropped writes do not corrupt the stored words or their order. It also shows that reads on an empty queue change neither the pointers nor the output.

A reset issued mid-fill shows that both pointers are cleared together.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  // Output style selector
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  // Occupancy from two pointers of (aw+1) bits
  function automatic int unsigned ptr_gap(int unsigned wp, int unsigned rp, int unsigned aw);
    return (wp - rp) & ((32'd1 << (aw + 1)) - 32'd1);
  endfunction

  // Wrapped: same address bits, different lap bit
  function automatic logic ptr_wrapped(int unsigned wp, int unsigned rp, int unsigned aw);
    int unsigned diff;
    diff = wp ^ rp;
    return (((diff >> aw) & 32'd1) == 32'd1) && ((diff & ((32'd1 << aw) - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/fifo_ptrs.sv
module fifo_ptrs
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              wr_fire,
  output logic              rd_fire
);

  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign level   = PTR_W'(ptr_gap(32'(wr_ptr), 32'(rd_ptr), ADDR_W));
  assign empty   = (level == '0);
  assign full    = ptr_wrapped(32'(wr_ptr), 32'(rd_ptr), ADDR_W);
  assign wr_fire = wr_req & ~full;
  assign rd_fire = rd_req & ~empty;
  assign wr_addr = wr_ptr[ADDR_W-1:0];
  assign rd_addr = rd_ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
  import fifo_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter int         ADDR_W = 4,
  parameter fifo_mode_e MODE   = MODE_FWFT,
  localparam int        PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);

  // Named internal events, visible to the bound checker
  logic              wr_req;
  logic              wr_fire;
  logic              rd_fire;
  logic              bypass_fire;
  logic [PTR_W-1:0]  level;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] store_q;

  assign wr_req = wr_en & ~bypass_fire;

  fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .rd_req  (rd_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .level   (level),
    .empty   (empty),
    .full    (full),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (store_q)
  );

  generate
    if (MODE == MODE_FWFT) begin : g_fwft
      // Head word shown directly; empty queue bypasses a same-cycle write
      assign bypass_fire = empty & rd_en & wr_en;
      assign rd_data     = empty ? (bypass_fire ? wr_data : '0) : store_q;
    end else begin : g_std
      // Registered output, loaded only by an accepted read
      assign bypass_fire = 1'b0;
      always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (rd_fire) rd_data <= store_q;
      end
    end
  endgenerate

endmodule

// File: rtl/fallthru_fifo_chk.sv
module fallthru_fifo_chk
  import fifo_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter int         ADDR_W = 4,
  parameter fifo_mode_e MODE   = MODE_FWFT
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty,
  input logic              full,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              bypass_fire,
  input logic [ADDR_W:0]   level
);

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_fire);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rd_fire);

  assert_level_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && rd_fire) |=> $stable(level));

  generate
    if (MODE == MODE_FWFT) begin : g_fwft_chk
      assert_bypass_data_R8: assert property (@(posedge clk) disable iff (rst)
        bypass_fire |-> (rd_data == wr_data));
      assert_bypass_stays_empty_R8: assert property (@(posedge clk) disable iff (rst)
        bypass_fire |=> empty);
    end else begin : g_std_chk
      assert_hold_on_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rd_data));
      assert_no_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && empty) |=> !empty);
    end
  endgenerate

endmodule

bind fallthru_fifo fallthru_fifo_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .MODE   (MODE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .empty       (empty),
  .full        (full),
  .wr_fire     (wr_fire),
  .rd_fire     (rd_fire),
  .bypass_fire (bypass_fire),
  .level       (level)
);

// File: tb/fallthru_fifo_tb.sv
module fallthru_fifo_tb;
  import fifo_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 20;

  // Each entry: {wr_en, rd_en, wr_data}
  localparam logic [DW+1:0] VEC [NVEC] = '{
    {2'b11, 8'hA1}, {2'b00, 8'h00}, {2'b10, 8'hB2}, {2'b10, 8'hC3},
    {2'b00, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'hD4}, {2'b01, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'hE5}, {2'b00, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b10, 8'hF6}, {2'b11, 8'h17},
    {2'b11, 8'h28}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dout_f, dout_s;
  logic empty_f, full_f, empty_s, full_s;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [DW-1:0] qf[$];
  logic [DW-1:0] qs[$];
  logic [DW-1:0] std_exp = '0;
  string std_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fallthru_fifo #(.DATA_W(DW), .ADDR_W(AW), .MODE(MODE_FWFT)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(dout_f), .empty(empty_f), .full(full_f)
  );

  fallthru_fifo #(.DATA_W(DW), .ADDR_W(AW), .MODE(MODE_STD)) u_dut_std (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(dout_s), .empty(empty_s), .full(full_s)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic w, logic r, logic [DW-1:0] d);
    int sf;
    int ss;
    logic [DW-1:0] exp_f;
    string ftag;
    string flag_tag;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    #1;
    sf = qf.size();
    ss = qs.size();
    // Fall-through copy: combinational view
    if (sf == 0) begin
      exp_f = (w && r) ? d : '0;
      ftag = "R8";
    end else begin
      exp_f = qf[0];
      ftag = "R7 R4";
    end
    flag_tag = (w && r && sf != 0) ? "R9" : "R2";
    check(ftag, "fwft rd_data", 32'(dout_f), 32'(exp_f));
    check(flag_tag, "fwft empty", 32'(empty_f), 32'(sf == 0));
    check("R3", "fwft full", 32'(full_f), 32'(sf == DEPTH));
    // Standard copy: registered view from the previous edge
    check(std_tag, "std rd_data", 32'(dout_s), 32'(std_exp));
    check("R2", "std empty", 32'(empty_s), 32'(ss == 0));
    check("R3", "std full", 32'(full_s), 32'(ss == DEPTH));
    // Model the coming edge
    if (sf != 0) begin
      if (r) void'(qf.pop_front());
      if (w && sf < DEPTH) qf.push_back(d);
    end else if (w && !r) begin
      qf.push_back(d);
    end
    if (r && ss != 0) begin
      std_exp = qs.pop_front();
      std_tag = "R5 R4";
    end else if (r) begin
      std_tag = "R6";
    end else begin
      std_tag = "R5";
    end
    if (w && ss < DEPTH) qs.push_back(d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    qf.delete(); qs.delete();
    std_exp = '0; std_tag = "R1";
    #1;
    check("R1", "fwft empty", 32'(empty_f), 32'd1);
    check("R1", "fwft full", 32'(full_f), 32'd0);
    check("R1", "fwft rd_data", 32'(dout_f), 32'd0);
    check("R1", "std empty", 32'(empty_s), 32'd1);
    check("R1", "std full", 32'(full_s), 32'd0);
    check("R1", "std rd_data", 32'(dout_s), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Table of mixed cycles
    for (int i = 0; i < NVEC; i++) step(VEC[i][DW+1], VEC[i][DW], VEC[i][DW-1:0]);
    // R3: fill past capacity, then drain past empty (R6 on the extra reads)
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 1'b0, DW'(8'h40 + i));
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, DW'(8'h90 + i));
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    // R8: repeated bypass cycles on an empty queue
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, DW'(8'hC0 + i));
    step(1'b0, 1'b0, '0);
    // R1: reset in the middle of a fill
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(8'h20 + i));
    do_reset();
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 8'h5A);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule